// File: doc/BRIEF.md
# GPIO Bank with Change Interrupt and Capture Mode

This block is an eight-pin general-purpose I/O bank reached through a simple register port: a 4-bit index, a write strobe with write data, and a read strobe with combinational read data. Software uses it to do four things:

- set each pin as an input or an output,
- drive levels on the output pins,
- read back the pin levels,
- choose which input pins may raise a change interrupt.

The interrupt output is an enable for an external active-low open-drain line. When it is 1, the line is pulled low.

Each pin runs a small state machine. Its states are `PIN_IDLE`, `PIN_PEND` and `PIN_HELD`. Each pin compares its synchronised level with a stored reference level.

- In plain mode a difference moves the pin `PIN_IDLE -> PIN_PEND`. The pin returns `PIN_PEND -> PIN_IDLE` either when the state register is read or when the level goes back to the reference.
- In capture mode a difference moves the pin `PIN_IDLE -> PIN_HELD` and stores the new level. The pin stays in `PIN_HELD`, and the state register shows the stored level, until a state read returns it `PIN_HELD -> PIN_IDLE`.
- A direction write or a soft reset forces every pin to `PIN_IDLE` from any state.
- While a pin is in `PIN_IDLE`, a state read loads its reference from the current level. While the pin is not armed, the reference follows the level on every cycle.

A self-clearing soft-reset bit in the control register returns the whole bank to its reset configuration.

Top module: `gpx_bank`

## Requirements
- R1: After hardware reset the direction, output-value, interrupt-enable and control registers read 0. Every pin_oe bit is 0 and irq_oe is 0.
- R2: Direction register bit n set to 1 makes pin n an output (pin_oe[n]=1). Set to 0, it makes pin n an input.
- R3: A write to the state register stores the value that pin_out drives. A state read returns, per bit:
  - the driven value for an output pin,
  - the synchronised pin_in level for an input pin in `PIN_IDLE` or `PIN_PEND`,
  - the captured level for a pin in `PIN_HELD`.
- R4: Only an input pin whose interrupt-enable bit is 1 can raise the interrupt. While a pin is output or disabled, its reference follows its level, so enabling it does not fire on earlier changes.
- R5: With control bit 0 = 0 (plain mode), a pending pin clears on a state read. It also clears by itself when its level returns to the reference.
- R6: With control bit 0 = 1 (capture mode), a change latches the new level. The interrupt and that level stay held even if the pin reverts. A state read returns the latched level and clears the interrupt. The next read returns the live level.
- R7: Any write to the direction register clears all pending pins. irq_oe is 0 in the following cycle, and the current levels become the new references.
- R8: irq_oe is the OR of all pending pins. It rises on the third rising clock edge after a pin_in change: two synchroniser stages plus one state update.
- R9: Writing control bit 3 = 1 clears the direction, output-value, interrupt-enable and control registers and all pending pins in the next cycle. Bit 3 always reads 0.
- R10: The reserved indices (0x0–0x9, 0xD, 0xF) read 0, and writes to them change nothing.
- R11: Register indices: direction 0xA, state 0xB, interrupt enable 0xC, control 0xE with mode at bit 0 and soft reset at bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects of a state read) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current index |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_out | output | 8 | Output value for pins |
| pin_oe | output | 8 | Per-pin output enable |
| irq_oe | output | 1 | Pull-down enable of the open-drain interrupt line |

## Verification
The state register is read under several mixes of direction, written value and pin level. This separates output pins, which read the written value, from input pins, which read the pin. Single-pin pulses are then applied in both modes:
- A pulse that reverts before the read tells plain-mode self-clearing apart from capture-mode holding.
- A second read after a capture shows the live level.
- A change on a disabled pin followed by an enable shows that the reference follows the level while the pin is not armed.
- Direction writes and soft reset are each issued with an interrupt pending, to show the release.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] IDX_DIR   = 4'hA;
    localparam logic [ADDR_W-1:0] IDX_STATE = 4'hB;
    localparam logic [ADDR_W-1:0] IDX_IEN   = 4'hC;
    localparam logic [ADDR_W-1:0] IDX_CTL   = 4'hE;

    localparam int MODE_BIT = 0;
    localparam int SRST_BIT = 3;

    typedef enum logic [1:0] {
        PIN_IDLE = 2'd0,
        PIN_PEND = 2'd1,
        PIN_HELD = 2'd2
    } pin_state_e;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpx_pin_ctl.sv
module gpx_pin_ctl
    import gpx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic dir_wr,
    input  logic rd_state,
    input  logic lvl,
    input  logic armed,
    input  logic capture_mode,
    output logic pend,
    output logic held,
    output logic cap_lvl
);
    pin_state_e state_q, state_d;
    logic       ref_q, ref_d;
    logic       cap_q, cap_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIN_IDLE;
            ref_q   <= 1'b0;
            cap_q   <= 1'b0;
        end else if (srst) begin
            state_q <= PIN_IDLE;
            ref_q   <= lvl;
            cap_q   <= 1'b0;
        end else if (dir_wr) begin
            state_q <= PIN_IDLE;
            ref_q   <= lvl;
        end else begin
            state_q <= state_d;
            ref_q   <= ref_d;
            cap_q   <= cap_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ref_d   = ref_q;
        cap_d   = cap_q;
        unique case (state_q)
            PIN_IDLE: begin
                if (rd_state || !armed) begin
                    ref_d = lvl;
                end else if (lvl != ref_q) begin
                    if (capture_mode) begin
                        state_d = PIN_HELD;
                        cap_d   = lvl;
                    end else begin
                        state_d = PIN_PEND;
                    end
                end
            end
            PIN_PEND: begin
                if (rd_state) begin
                    state_d = PIN_IDLE;
                    ref_d   = lvl;
                end else if (lvl == ref_q) begin
                    state_d = PIN_IDLE;
                end
            end
            PIN_HELD: begin
                if (rd_state) begin
                    state_d = PIN_IDLE;
                    ref_d   = lvl;
                end
            end
            default: state_d = PIN_IDLE;
        endcase
    end

    always_comb begin
        pend    = (state_q != PIN_IDLE);
        held    = (state_q == PIN_HELD);
        cap_lvl = cap_q;
    end

    AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_IDLE && !armed) |=> (state_q == PIN_IDLE)); // R4

    AST_PEND_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_PEND && lvl == ref_q) |=> (state_q == PIN_IDLE)); // R5

    AST_HELD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PIN_HELD && !rd_state && !dir_wr && !srst)
        |=> (state_q == PIN_HELD && $stable(cap_q))); // R6
endmodule

// File: rtl/gpx_regs.sv
module gpx_regs
    import gpx_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [N-1:0]      wdata,
    input  logic [N-1:0]      state_view,
    output logic [N-1:0]      rdata,
    output logic [N-1:0]      dir_q,
    output logic [N-1:0]      outv_q,
    output logic [N-1:0]      ien_q,
    output logic              mode_q,
    output logic              srst,
    output logic              dir_wr,
    output logic              rd_state
);
    assign srst     = wr && (addr == IDX_CTL) && wdata[SRST_BIT];
    assign dir_wr   = wr && (addr == IDX_DIR);
    assign rd_state = rd && (addr == IDX_STATE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            outv_q <= '0;
            ien_q  <= '0;
            mode_q <= 1'b0;
        end else if (srst) begin
            dir_q  <= '0;
            outv_q <= '0;
            ien_q  <= '0;
            mode_q <= 1'b0;
        end else if (wr) begin
            case (addr)
                IDX_DIR:   dir_q  <= wdata;
                IDX_STATE: outv_q <= wdata;
                IDX_IEN:   ien_q  <= wdata;
                IDX_CTL:   mode_q <= wdata[MODE_BIT];
                default:   ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            IDX_DIR:   rdata = dir_q;
            IDX_STATE: rdata = state_view;
            IDX_IEN:   rdata = ien_q;
            IDX_CTL:   rdata[MODE_BIT] = mode_q;
            default:   rdata = '0;
        endcase
    end

    AST_RSV_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != IDX_DIR && addr != IDX_STATE && addr != IDX_IEN && addr != IDX_CTL)
        |=> ($stable(dir_q) && $stable(outv_q) && $stable(ien_q) && $stable(mode_q))); // R10

    AST_SRST_CLEARS_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (dir_q == '0 && ien_q == '0 && outv_q == '0 && !mode_q)); // R9

    AST_SRST_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == IDX_CTL) |-> (rdata[SRST_BIT] == 1'b0)); // R9
endmodule

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
#(
    parameter int N_PINS      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [N_PINS-1:0] reg_wdata,
    output logic [N_PINS-1:0] reg_rdata,
    input  logic [N_PINS-1:0] pin_in,
    output logic [N_PINS-1:0] pin_out,
    output logic [N_PINS-1:0] pin_oe,
    output logic              irq_oe
);
    logic [N_PINS-1:0] lvl;
    logic [N_PINS-1:0] dir_q, outv_q, ien_q;
    logic              mode_q, srst, dir_wr, rd_state;
    logic [N_PINS-1:0] pend, held, cap_lvl, state_view;

    gpx_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (lvl)
    );

    gpx_regs #(.N(N_PINS)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .wr         (reg_wr),
        .rd         (reg_rd),
        .wdata      (reg_wdata),
        .state_view (state_view),
        .rdata      (reg_rdata),
        .dir_q      (dir_q),
        .outv_q     (outv_q),
        .ien_q      (ien_q),
        .mode_q     (mode_q),
        .srst       (srst),
        .dir_wr     (dir_wr),
        .rd_state   (rd_state)
    );

    generate
        for (genvar i = 0; i < N_PINS; i++) begin : g_pin
            gpx_pin_ctl u_pin (
                .clk          (clk),
                .rst_n        (rst_n),
                .srst         (srst),
                .dir_wr       (dir_wr),
                .rd_state     (rd_state),
                .lvl          (lvl[i]),
                .armed        (ien_q[i] && !dir_q[i]),
                .capture_mode (mode_q),
                .pend         (pend[i]),
                .held         (held[i]),
                .cap_lvl      (cap_lvl[i])
            );
            assign state_view[i] = held[i]  ? cap_lvl[i] :
                                   dir_q[i] ? outv_q[i]  : lvl[i];
        end
    endgenerate

    assign pin_out = outv_q;
    assign pin_oe  = dir_q;
    assign irq_oe  = |pend;

    AST_DIR_WR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> !irq_oe); // R7

    AST_SRST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (!irq_oe && pin_oe == '0)); // R9

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_oe && !(|(ien_q & ~dir_q))) |=> !irq_oe); // R8
endmodule

// File: tb/tb_gpx_bank.sv
`timescale 1ns/1ps
module tb_gpx_bank;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, pin_out, pin_oe;
    logic [7:0] pin_in = '0;
    logic       irq_oe;
    int         total = 0, bad = 0;
    logic [7:0] rv;

    always #HALF clk = ~clk;

    gpx_bank dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_oe(irq_oe)
    );

    typedef struct packed {
        logic [7:0] dir;
        logic [7:0] wval;
        logic [7:0] pins;
        logic [7:0] exp;
    } vec_t;

    // R3: output bits read the written value, input bits read the pin
    localparam vec_t VECS [6] = '{
        '{8'h00, 8'hFF, 8'hA5, 8'hA5},
        '{8'hFF, 8'h3C, 8'h00, 8'h3C},
        '{8'hF0, 8'hAA, 8'h0F, 8'hAF},
        '{8'h0F, 8'h55, 8'hC3, 8'hC5},
        '{8'h81, 8'hFF, 8'h00, 8'h81},
        '{8'h3C, 8'h00, 8'hFF, 8'hC3}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(2 * HALF * 200000);
        bad++; total++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        chk("R1 pin_oe", pin_oe, 8'h00);
        chk("R1 irq_oe", {7'b0, irq_oe}, 8'h00);
        rd_reg(4'hA, rv); chk("R1 dir", rv, 8'h00);
        rd_reg(4'hC, rv); chk("R1 ien", rv, 8'h00);
        rd_reg(4'hE, rv); chk("R1 ctl", rv, 8'h00);

        // R2 R3 table walk
        foreach (VECS[i]) begin
            wr_reg(4'hA, VECS[i].dir);
            wr_reg(4'hB, VECS[i].wval);
            @(negedge clk) pin_in = VECS[i].pins;
            cyc(3);
            chk("R2 pin_oe", pin_oe, VECS[i].dir);
            chk("R3 pin_out", pin_out, VECS[i].wval);
            rd_reg(4'hB, rv); chk("R3 state read", rv, VECS[i].exp);
        end

        // R4 disabled and output pins stay quiet
        wr_reg(4'hA, 8'h00);
        @(negedge clk) pin_in = 8'h00;
        cyc(4);
        @(negedge clk) pin_in[2] = 1'b1;
        cyc(4);
        chk("R4 disabled pin", {7'b0, irq_oe}, 8'h00);
        wr_reg(4'hC, 8'h04);
        rd_reg(4'hC, rv); chk("R11 ien readback", rv, 8'h04);
        cyc(4);
        chk("R4 reference tracked", {7'b0, irq_oe}, 8'h00);
        @(negedge clk) pin_in[5] = 1'b1;
        cyc(4);
        chk("R4 other pin", {7'b0, irq_oe}, 8'h00);

        // R8 latency: rises on 3rd edge
        @(negedge clk) pin_in[2] = 1'b0;
        cyc(2);
        chk("R8 early", {7'b0, irq_oe}, 8'h00);
        cyc(1);
        chk("R8 third edge", {7'b0, irq_oe}, 8'h01);

        // R5 plain mode: read clears, revert clears
        rd_reg(4'hB, rv); chk("R5 read value", rv, 8'h20);
        chk("R5 cleared by read", {7'b0, irq_oe}, 8'h00);
        @(negedge clk) pin_in[2] = 1'b1;
        cyc(4);
        chk("R5 pending", {7'b0, irq_oe}, 8'h01);
        @(negedge clk) pin_in[2] = 1'b0;
        cyc(4);
        chk("R5 self clear", {7'b0, irq_oe}, 8'h00);

        // R6 capture mode
        wr_reg(4'hE, 8'h01);
        rd_reg(4'hE, rv); chk("R11 ctl mode", rv, 8'h01);
        @(negedge clk) pin_in[2] = 1'b1;
        cyc(4);
        @(negedge clk) pin_in[2] = 1'b0;
        cyc(4);
        chk("R6 held irq", {7'b0, irq_oe}, 8'h01);
        rd_reg(4'hB, rv); chk("R6 captured", rv, 8'h24);
        chk("R6 read clears", {7'b0, irq_oe}, 8'h00);
        rd_reg(4'hB, rv); chk("R6 live next", rv, 8'h20);

        // R7 direction write cancels
        @(negedge clk) pin_in[2] = 1'b1;
        cyc(4);
        chk("R7 pending", {7'b0, irq_oe}, 8'h01);
        wr_reg(4'hA, 8'h00);
        chk("R7 released", {7'b0, irq_oe}, 8'h00);
        cyc(5);
        chk("R7 stays released", {7'b0, irq_oe}, 8'h00);
        rd_reg(4'hB, rv); chk("R7 live state", rv, 8'h24);

        // R9 soft reset
        wr_reg(4'hA, 8'hF0);
        wr_reg(4'hC, 8'hFF);
        chk("R2 upper outputs", pin_oe, 8'hF0);
        @(negedge clk) pin_in[0] = 1'b1;
        cyc(4);
        chk("R9 pending before", {7'b0, irq_oe}, 8'h01);
        wr_reg(4'hE, 8'h08);
        chk("R9 irq released", {7'b0, irq_oe}, 8'h00);
        chk("R9 pin_oe", pin_oe, 8'h00);
        rd_reg(4'hA, rv); chk("R9 dir", rv, 8'h00);
        rd_reg(4'hC, rv); chk("R9 ien", rv, 8'h00);
        rd_reg(4'hE, rv); chk("R9 ctl bit3 reads 0", rv, 8'h00);

        // R10 reserved indices
        wr_reg(4'hD, 8'hFF);
        wr_reg(4'h0, 8'hFF);
        rd_reg(4'hD, rv); chk("R10 read 0xD", rv, 8'h00);
        rd_reg(4'h0, rv); chk("R10 read 0x0", rv, 8'h00);
        rd_reg(4'hF, rv); chk("R10 read 0xF", rv, 8'h00);
        rd_reg(4'hA, rv); chk("R10 dir untouched", rv, 8'h00);
        rd_reg(4'hC, rv); chk("R10 ien untouched", rv, 8'h00);
        chk("R10 pin_out untouched", pin_out, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule